// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a 32-bit word-oriented RISC core and decides, every cycle, which address is fetched next. A decoder outside the block classifies the current instruction into one of five flow classes: sequential, jump, jump-and-link, jump-through-register and conditional branch. The unit takes that class, the raw instruction word and the two register operands read for it. From these it computes the candidate addresses, evaluates the branch condition itself and loads the chosen address into the PC on the next clock edge, but only when the advance enable is high.

Four next-address sources exist, and the selection logic moves among them as a set of named selections. SRC_SEQ steps to PC+4. SRC_BRANCH takes the PC-relative target. SRC_JUMP takes the pseudodirect target. SRC_REG takes the register operand. A jump or jump-and-link class always goes to SRC_JUMP. A jump-through-register class goes to SRC_REG. A branch class goes to SRC_BRANCH when its condition holds and otherwise falls to SRC_SEQ. Every other class value goes to SRC_SEQ. For jump-and-link, the unit also raises a write enable for the return-address register, register 31, and presents PC+4 as the value to write.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC loads 0x00000000. `link_we` is low whenever `rst` is high.
- R2: When `adv_en` is low, the PC keeps its value across the clock edge, whatever the class and operands. `link_we` is low in that cycle.
- R3: For class 0 (sequential), and for the unused class codes 5 to 7, the PC becomes PC+4, modulo 2^32.
- R4: For class 1 (jump), the PC becomes the concatenation of bits 31..28 of PC+4, instruction bits 25..0, and two zero bits.
- R5: For class 2 (jump-and-link), `link_we` is 1 and `link_data` equals PC+4 in the cycle before the edge. The PC then takes the same target as in R4.
- R6: For class 3 (jump-through-register), the PC becomes the full 32-bit `rs_data`.
- R7: For class 4 (branch) with opcode 4 (instruction bits 31..26), the branch is taken exactly when `rs_data` equals `rt_data`.
- R8: For class 4 with opcode 5, the branch is taken exactly when `rs_data` differs from `rt_data`.
- R9: For class 4 with opcode 1, the branch is taken exactly when bit 31 of `rs_data` is 1, that is, when it is negative as a signed value.
- R10: A taken branch loads PC+4 plus the sign-extended 16-bit immediate (instruction bits 15..0) shifted left by 2, modulo 2^32. A branch that is not taken loads PC+4.
- R11: For class 4 with any other opcode, the branch is not taken and the PC becomes PC+4.
- R12: `link_we` is 1 only in a cycle whose class is 2 and in which `adv_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; the PC updates only when high |
| instr | input | 32 | Instruction word fetched at the current PC |
| rs_data | input | 32 | First register operand |
| rt_data | input | 32 | Second register operand |
| flow_class | input | 3 | Flow class: 0 sequential, 1 jump, 2 jump-and-link, 3 jump-through-register, 4 branch |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Write enable for the return-address register |
| link_data | output | 32 | Return address, PC+4 |

## Verification
The assertions assume that `flow_class`, `instr` and both operands are stable and known from one falling edge to the next rising edge. They also assume that the decoder's class is consistent with the opcode only where the unit itself decodes the opcode, which is inside the branch class. The stimulus applies every input change at the falling edge and holds it through the rising edge. It reaches arbitrary PC values only through jump-through-register steps, so the bench's model of the PC is always defined. Branch opcodes are swept over a set that includes codes the unit must ignore, and these are combined with operand pairs that place the equality and sign cases on both sides of each condition.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Flow classes presented by the external decoder
    typedef enum logic [2:0] {
        CC_SEQ    = 3'd0,
        CC_JUMP   = 3'd1,
        CC_JAL    = 3'd2,
        CC_JREG   = 3'd3,
        CC_BRANCH = 3'd4
    } flow_class_e;

    // Next-address source selections
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_REG    = 2'd3
    } next_src_e;

    // Branch opcodes decoded inside the unit
    localparam logic [5:0] OPC_BLTZ = 6'd1;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_BNE  = 6'd5;

endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
    import pcu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OP_W   = 6
) (
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              cond_true
);

    localparam int SIGN_BIT = DATA_W - 1;

    logic ops_equal;
    logic a_negative;

    assign ops_equal  = (src_a == src_b);
    assign a_negative = src_a[SIGN_BIT];

    always_comb begin
        unique case (opcode)
            OP_W'(OPC_BEQ):  cond_true = ops_equal;         // R7
            OP_W'(OPC_BNE):  cond_true = !ops_equal;        // R8
            OP_W'(OPC_BLTZ): cond_true = a_negative;        // R9
            default:         cond_true = 1'b0;              // R11
        endcase
    end

endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 26,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [TGT_W-1:0]  jmp_field,
    input  logic [IMM_W-1:0]  imm_field,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] br_addr,
    output logic [ADDR_W-1:0] jmp_addr
);

    localparam int BYTE_SH = 2;
    localparam int HI_W    = ADDR_W - TGT_W - BYTE_SH;
    localparam int EXT_W   = ADDR_W - IMM_W - BYTE_SH;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << BYTE_SH);

    logic [ADDR_W-1:0] br_disp;

    assign seq_addr = cur_pc + STEP;

    // word offset, sign-extended, turned into bytes
    assign br_disp  = {{EXT_W{imm_field[IMM_W-1]}}, imm_field, {BYTE_SH{1'b0}}};
    assign br_addr  = seq_addr + br_disp;

    // upper bits come from the incremented PC
    assign jmp_addr = {seq_addr[ADDR_W-1 -: HI_W], jmp_field, {BYTE_SH{1'b0}}};

endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        flow_code,
    input  logic              cond_true,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              link_req
);

    flow_class_e cls;
    next_src_e   src;

    assign cls = flow_class_e'(flow_code);

    // class to source selection
    always_comb begin
        link_req = 1'b0;
        unique case (cls)
            CC_JUMP:   src = SRC_JUMP;
            CC_JAL: begin
                src      = SRC_JUMP;
                link_req = 1'b1;
            end
            CC_JREG:   src = SRC_REG;
            CC_BRANCH: src = cond_true ? SRC_BRANCH : SRC_SEQ;
            default:   src = SRC_SEQ;
        endcase
    end

    // source to address
    always_comb begin
        unique case (src)
            SRC_BRANCH: next_addr = br_addr;
            SRC_JUMP:   next_addr = jmp_addr;
            SRC_REG:    next_addr = reg_addr;
            default:    next_addr = seq_addr;
        endcase
    end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 26,
    parameter int IMM_W  = 16,
    parameter int OP_W   = 6,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic [ADDR_W-1:0] instr,
    input  logic [ADDR_W-1:0] rs_data,
    input  logic [ADDR_W-1:0] rt_data,
    input  logic [2:0]        flow_class,
    output logic [ADDR_W-1:0] pc,
    output logic              link_we,
    output logic [ADDR_W-1:0] link_data
);

    localparam int OP_LSB = ADDR_W - OP_W;

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              cond_true;
    logic              link_req;
    logic [OP_W-1:0]   opcode;

    assign opcode = instr[ADDR_W-1:OP_LSB];

    pcu_target_gen #(
        .ADDR_W (ADDR_W),
        .TGT_W  (TGT_W),
        .IMM_W  (IMM_W)
    ) u_tgen (
        .cur_pc    (pc),
        .jmp_field (instr[TGT_W-1:0]),
        .imm_field (instr[IMM_W-1:0]),
        .seq_addr  (seq_addr),
        .br_addr   (br_addr),
        .jmp_addr  (jmp_addr)
    );

    pcu_cond_eval #(
        .DATA_W (ADDR_W),
        .OP_W   (OP_W)
    ) u_cond (
        .opcode    (opcode),
        .src_a     (rs_data),
        .src_b     (rt_data),
        .cond_true (cond_true)
    );

    pcu_next_sel #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .flow_code (flow_class),
        .cond_true (cond_true),
        .seq_addr  (seq_addr),
        .br_addr   (br_addr),
        .jmp_addr  (jmp_addr),
        .reg_addr  (rs_data),
        .next_addr (next_addr),
        .link_req  (link_req)
    );

    // PC register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= RESET_PC;
        end else if (adv_en) begin
            pc <= next_addr;
        end
    end

    assign link_we   = adv_en && link_req && !rst;
    assign link_data = seq_addr;

    // ---------------- assertions ----------------
    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC)) else $error("reset load");                              // R1

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> $stable(pc)) else $error("pc moved while stalled");                  // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_en && flow_class == 3'(CC_SEQ)) |=> (pc == $past(pc) + 32'd4))
        else $error("sequential step");                                                  // R3

    AST_JREG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (adv_en && flow_class == 3'(CC_JREG)) |=> (pc == $past(rs_data)))
        else $error("register jump");                                                    // R6

    AST_BR_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (adv_en && flow_class == 3'(CC_BRANCH) && opcode != OP_W'(OPC_BEQ)
         && opcode != OP_W'(OPC_BNE) && opcode != OP_W'(OPC_BLTZ))
        |=> (pc == $past(pc) + 32'd4)) else $error("unknown branch opcode taken");       // R11

    AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (adv_en && flow_class == 3'(CC_JAL))) else $error("stray link");     // R12

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_data == pc + 32'd4)) else $error("link value");                // R5

endmodule

// File: tb/pc_next_unit_tb.sv
module pc_next_unit_tb;

    logic        clk;
    logic        rst;
    logic        adv_en;
    logic [31:0] instr;
    logic [31:0] rs_data;
    logic [31:0] rt_data;
    logic [2:0]  flow_class;
    logic [31:0] pc;
    logic        link_we;
    logic [31:0] link_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_pc;

    pc_next_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .adv_en     (adv_en),
        .instr      (instr),
        .rs_data    (rs_data),
        .rt_data    (rt_data),
        .flow_class (flow_class),
        .pc         (pc),
        .link_we    (link_we),
        .link_data  (link_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected next PC, from the requirements
    function automatic logic [31:0] model_next(input logic [2:0] cls, input logic [31:0] ins,
                                               input logic [31:0] a, input logic [31:0] b,
                                               input logic [31:0] cur);
        logic [31:0] inc;
        logic        tk;
        inc = cur + 32'd4;
        case (cls)
            3'd1, 3'd2: return {inc[31:28], ins[25:0], 2'b00};
            3'd3:       return a;
            3'd4: begin
                case (ins[31:26])
                    6'd4:    tk = (a == b);
                    6'd5:    tk = (a != b);
                    6'd1:    tk = a[31];
                    default: tk = 1'b0;
                endcase
                if (tk) return inc + {{14{ins[15]}}, ins[15:0], 2'b00};
                return inc;
            end
            default: return inc;
        endcase
    endfunction

    task automatic step(input string req, input logic [2:0] cls, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input logic adv);
        @(negedge clk);
        flow_class = cls; instr = ins; rs_data = a; rt_data = b; adv_en = adv;
        #1;
        check("R12", {31'd0, link_we}, {31'd0, adv && cls == 3'd2});
        if (adv && cls == 3'd2) check("R5", link_data, exp_pc + 32'd4);
        @(posedge clk);
        #1;
        if (adv) exp_pc = model_next(cls, ins, a, b, exp_pc);
        check(req, pc, exp_pc);
    endtask

    task automatic set_pc(input logic [31:0] v);
        step("R6", 3'd3, 32'h0000_0008, v, 32'd0, 1'b1);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] vals [5];
        logic [5:0]  ops  [5];
        logic [15:0] imms [8];
        vals = '{32'd0, 32'd1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
        ops  = '{6'd4, 6'd5, 6'd1, 6'd0, 6'd6};
        imms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0010, 16'hFFF0, 16'h1234};
        rst = 1'b1; adv_en = 1'b1; instr = '0; rs_data = '0; rt_data = '0; flow_class = 3'd2;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset value, no link during reset even with a link class
        check("R1", pc, 32'd0);
        check("R1", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        exp_pc = 32'd0;

        // R3: sequential and unused class codes
        for (int c = 0; c < 8; c++)
            if (c == 0 || c >= 5) step("R3", 3'(c), 32'hDEAD_BEEF, 32'h5, 32'h5, 1'b1);

        // R2: stalls with every class
        for (int c = 0; c < 8; c++)
            step("R2", 3'(c), 32'h1000_0040, 32'h8000_0000, 32'h8000_0000, 1'b0);

        // R4 / R5: jumps from several regions, including a region carry on PC+4
        for (int u = 0; u < 4; u++) begin
            logic [31:0] bases [4];
            logic [25:0] tg    [4];
            bases = '{32'h0000_0100, 32'h5FFF_FFFC, 32'hA000_0000, 32'hFFFF_FFFC};
            tg    = '{26'h0, 26'h3FF_FFFF, 26'h155_5555, 26'h2AA_AAAA};
            set_pc(bases[u]);
            step("R4", 3'd1, {6'd2, tg[u]}, 32'h0, 32'h0, 1'b1);
            set_pc(bases[u]);
            step("R5", 3'd2, {6'd3, tg[3-u]}, 32'h0, 32'h0, 1'b1);
        end

        // R7 R8 R9 R11: opcode and operand sweep
        for (int o = 0; o < 5; o++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++) begin
                    set_pc(32'h0000_1000);
                    step(o == 0 ? "R7" : o == 1 ? "R8" : o == 2 ? "R9" : "R11",
                         3'd4, {ops[o], 10'd0, 16'h0020}, vals[i], vals[j], 1'b1);
                end

        // R10: offset extremes, forward and backward, with wraparound near zero
        for (int k = 0; k < 8; k++) begin
            set_pc(32'h0004_0000);
            step("R10", 3'd4, {6'd4, 10'd0, imms[k]}, 32'h7, 32'h7, 1'b1);
            set_pc(32'h0000_0004);
            step("R10", 3'd4, {6'd1, 10'd0, imms[k]}, 32'hFFFF_FFFF, 32'h0, 1'b1);
        end

        // R6: register jump to an unaligned and a high value
        set_pc(32'h1234_5677);
        set_pc(32'hFFFF_FFFC);
        step("R3", 3'd0, 32'h0, 32'h0, 32'h0, 1'b1);

        // R1 again: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", pc, 32'd0);
        finish_run();
    end

endmodule